// File: doc/BRIEF.md
# Processor Reset Sequencer with Shutdown Detection

This block drives the processor's reset line from three sources. The first is an external hardware reset input. The second is a software command written to a control register. The third is an automatic trigger that fires when the processor runs a shutdown bus cycle, which the block decodes from the bus status lines. Software can turn the shutdown trigger on or off. After any reset, a small cause register can be read to find out which source raised it.

The hardware input also resets the block itself and passes straight through to the output. A software or shutdown trigger starts a fixed-length pulse that counts down on the clock. If a new trigger arrives while a pulse is running, the count starts again. The register port is a simple one-cycle write strobe with a one-bit address and an 8-bit write bus. Read data is combinational from the address.

Top module: `cpu_reset_ctl`

## Requirements
- R1: `cpu_reset` is high in every cycle in which `hw_rst_in` is high.
- R2: A clock edge with `hw_rst_in` high has these effects: the cause register becomes 3'b001, the shutdown enable becomes 0, and any running pulse is cancelled. `cpu_reset` falls in the first cycle after `hw_rst_in` is released, unless a new trigger arrives.
- R3: A write to address 0 with bit 0 set (the software command) raises `cpu_reset` at the write edge and holds it for exactly `PULSE_CYCLES` (default 62) cycles.
- R4: A software or shutdown trigger that arrives while a pulse is running restarts the count. `cpu_reset` then stays high for another full `PULSE_CYCLES` cycles from that edge.
- R5: When the shutdown enable is 1, an edge with `addr_strobe` high and `bus_status` equal to `SHDN_CODE` (default 3'b101) starts a `PULSE_CYCLES` pulse.
- R6: The status lines have no effect on `cpu_reset` or on the cause register in either of these cases: `addr_strobe` is low, or the shutdown enable is 0.
- R7: Reading address 1 returns the cause in bits [2:0]: 3'b010 for software, 3'b100 for shutdown, and 3'b110 when both trigger on the same edge. Bits [7:3] read as 0.
- R8: The shutdown enable is bit 1 of every write to address 0 and reads back at bit 1 of address 0; the other bits of address 0 read as 0. Writes made while `hw_rst_in` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_in | input | 1 | External hardware reset, active high; also resets the block |
| bus_status | input | 3 | Processor bus-cycle status code |
| addr_strobe | input | 1 | Qualifies `bus_status`, active high |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_addr | input | 1 | 0 = control, 1 = reset cause |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cpu_reset | output | 1 | Processor reset output, active high |

## Verification
A pulse counter left in the wrong state shows up at `cpu_reset` as a pulse that is one or more cycles too long or too short. This is visible the moment the pulse ends, so the bench measures every pulse to the exact cycle, including pulses restarted at many different offsets. A wrong enable bit or a wrong strobe qualifier shows up either as a pulse one edge after a status code that should have been ignored, or as a missing pulse. The sweep therefore covers every status code against both strobe and enable values. A wrong cause value can be seen on the read port in the cycle right after the triggering edge.

// File: rtl/cpu_reset_ctl.sv
module cpu_reset_ctl #(
  parameter int PULSE_CYCLES = 62,
  parameter int STATUS_W     = 3,
  parameter logic [STATUS_W-1:0] SHDN_CODE = 3'b101
) (
  input  logic                clk,
  input  logic                hw_rst_in,
  input  logic [STATUS_W-1:0] bus_status,
  input  logic                addr_strobe,
  input  logic                reg_wr,
  input  logic                reg_addr,
  input  logic [7:0]          reg_wdata,
  output logic [7:0]          reg_rdata,
  output logic                cpu_reset
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [2:0]    cause;
  logic          shdn_en;

  wire ctl_wr   = reg_wr && (reg_addr == 1'b0);
  wire sw_hit   = ctl_wr && reg_wdata[0];
  wire shdn_hit = shdn_en && addr_strobe && (bus_status == SHDN_CODE);

  always_ff @(posedge clk) begin
    if (hw_rst_in) begin
      cnt     <= '0;
      cause   <= 3'b001;
      shdn_en <= 1'b0;
    end else begin
      if (ctl_wr) shdn_en <= reg_wdata[1];
      if (sw_hit || shdn_hit) begin
        cnt   <= CW'(PULSE_CYCLES);
        cause <= {shdn_hit, sw_hit, 1'b0};
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign cpu_reset = hw_rst_in || (cnt != '0);
  assign reg_rdata = reg_addr ? {5'b0, cause} : {6'b0, shdn_en, 1'b0};

  // R2
  hw_clear_chk: assert property (@(posedge clk)
    hw_rst_in |=> (cause == 3'b001 && !shdn_en && cnt == '0));

  // R3
  pulse_end_chk: assert property (@(posedge clk) disable iff (hw_rst_in)
    ($fell(cpu_reset) && !$past(hw_rst_in)) |-> ($past(cnt) == CW'(1)));

  // R5
  shdn_fire_chk: assert property (@(posedge clk) disable iff (hw_rst_in)
    (addr_strobe && bus_status == SHDN_CODE && shdn_en) |=> (cpu_reset && cause[2]));

  // R6
  no_spurious_chk: assert property (@(posedge clk) disable iff (hw_rst_in)
    (!cpu_reset && !(reg_wr && !reg_addr && reg_wdata[0])
     && !(addr_strobe && bus_status == SHDN_CODE && shdn_en)) |=> !cpu_reset);

  // R7
  cause_shape_chk: assert property (@(posedge clk) disable iff (hw_rst_in)
    ($countones(cause) >= 1) && (cause[0] -> cause[2:1] == 2'b00));
endmodule

// File: tb/cpu_reset_ctl_bench.sv
module cpu_reset_ctl_bench;
  localparam int P = 62;
  localparam logic [2:0] CODE = 3'b101;

  logic clk = 0, hw_rst_in = 1, addr_strobe = 0, reg_wr = 0, reg_addr = 0;
  logic [2:0] bus_status = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic cpu_reset;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpu_reset_ctl u_cpu_reset_ctl (
    .clk(clk), .hw_rst_in(hw_rst_in), .bus_status(bus_status),
    .addr_strobe(addr_strobe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_reset(cpu_reset));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    reg_addr = 0; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic shdn(logic [2:0] st, logic stb);
    bus_status = st; addr_strobe = stb;
    @(negedge clk);
    addr_strobe = 0; bus_status = 0;
  endtask

  task automatic rd(logic a, output int v);
    reg_addr = a; #1 v = reg_rdata; reg_addr = 0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (cpu_reset && n < 300) begin n++; @(negedge clk); end
  endtask

  task automatic hw_pulse();
    hw_rst_in = 1; repeat (2) @(negedge clk); hw_rst_in = 0; @(negedge clk);
  endtask

  initial begin
    int v, n;
    @(negedge clk);
    chk("R1 reset held during hw", cpu_reset, 1);
    @(negedge clk);
    rd(1, v); chk("R2 cause after hw", v, 1);
    rd(0, v); chk("R2 enable after hw", v, 0);
    reg_addr = 0; reg_wdata = 8'h03; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    rd(0, v); chk("R8 write ignored during hw", v, 0);
    chk("R1 output high with hw", cpu_reset, 1);
    hw_rst_in = 0; @(negedge clk);
    chk("R2 output low after hw release", cpu_reset, 0);
    rd(1, v); chk("R8 cause unchanged by ignored write", v, 1);

    wr(8'h01); pulse_len(n); chk("R3 software pulse length", n, P);
    rd(1, v); chk("R7 software cause", v, 2);
    rd(0, v); chk("R8 enable stays 0", v, 0);

    for (int j = 0; j < P; j += 7) begin
      wr(8'h01);
      repeat (j) @(negedge clk);
      chk("R4 still high before restart", cpu_reset, 1);
      wr(8'h01); pulse_len(n); chk("R4 restarted length", n, P);
    end

    for (int en = 0; en < 2; en++)
      for (int stb = 0; stb < 2; stb++)
        for (int st = 0; st < 8; st++) begin
          hw_pulse();
          wr({6'b0, en[0], 1'b0});
          rd(0, v); chk("R8 enable readback", v, en * 2);
          shdn(st[2:0], stb[0]);
          if (en == 1 && stb == 1 && st == CODE) begin
            rd(1, v); chk("R7 shutdown cause", v, 4);
            pulse_len(n); chk("R5 shutdown pulse length", n, P);
          end else begin
            chk("R6 status ignored output", cpu_reset, 0);
            repeat (3) @(negedge clk);
            chk("R6 status ignored later", cpu_reset, 0);
            rd(1, v); chk("R6 cause unchanged", v, 1);
          end
        end

    hw_pulse(); wr(8'h02);
    for (int j = 5; j < P; j += 13) begin
      shdn(CODE, 1);
      repeat (j) @(negedge clk);
      shdn(CODE, 1); pulse_len(n); chk("R4 shutdown restart length", n, P);
    end

    bus_status = CODE; addr_strobe = 1; reg_addr = 0; reg_wdata = 8'h03; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0; addr_strobe = 0; bus_status = 0;
    rd(1, v); chk("R7 simultaneous cause", v, 6);
    pulse_len(n); chk("R3 pulse after joint trigger", n, P);

    wr(8'h01); repeat (10) @(negedge clk);
    hw_rst_in = 1; #1 chk("R1 hw during pulse", cpu_reset, 1);
    @(negedge clk); hw_rst_in = 0; @(negedge clk);
    chk("R2 pulse cancelled by hw", cpu_reset, 0);
    rd(1, v); chk("R2 cause hw after cancel", v, 1);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=finish"); end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule